// File: doc/BRIEF.md
# Audio Bit Clock Generator

This block produces the serial bit clock for one direction (transmit or receive) of a serial audio port. Four candidate source clocks arrive asynchronously. Each one is synchronised into the block's functional clock, and its rising edges become single-cycle ticks. A 2-bit selector picks one tick stream. The divider turns that stream into a bit clock with a 50% duty cycle, at an even ratio of the source.

In master mode the divided clock drives the output. In slave mode an externally supplied bit clock is passed through instead. When the path runs asynchronously, a swap control lets it borrow the opposite direction's bit clock. A status output reports whether the bit clock is running.

Integration has three rules. Configuration is changed only while the clock is stopped. Bit-clock-enable is raised before the channel that consumes the clock is enabled. When shutting down, the channel is dropped first and bit-clock-enable after it.

Top module: `audio_bclk_gen`

## Requirements
- R1: After reset `bclk_o` and `bclk_active_o` are both 0.
- R2: `src_sel` picks the divider source: 0 bus clock, 1 master-clock divider output, 2 peer bit clock 0, 3 peer bit clock 1.
- R3: With a divider field value f, the master-mode bit clock period is 2*(f+1) periods of the selected source, so only even ratios of 2 or more exist.
- R4: The divided clock is high for exactly half of its period: (f+1) source periods.
- R5: When bit-clock-enable rises from the stopped state, the toggle counter restarts from zero. The first pulse after enable is therefore a full-width high phase.
- R6: When bit-clock-enable is cleared, any high phase in progress runs to its full width. The output then stays low, and no runt pulse appears.
- R7: In slave mode (`master`=0) the output follows the external bit clock while bit-clock-enable is set, and is held low while it is clear.
- R8: When `swap` and `async_mode` are both 1, the output follows the opposite direction's bit clock. With `swap`=1 and `async_mode`=0 the swap has no effect.
- R9: A pulse of `soft_rst` forces the output low and clears the generation state. If enable remains high afterwards, generation resumes at the same ratio, starting with a full pulse.
- R10: `bclk_active_o` is 1 while the bit clock is running and returns to 0 once a disable has completed. `bclk_o` is never 1 while `bclk_active_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock that samples all sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of the generation state |
| bus_clk_i | input | 1 | Source 0: bus clock |
| mdiv_clk_i | input | 1 | Source 1: master-clock divider output |
| peer0_bclk_i | input | 1 | Source 2: bit clock of another audio instance |
| peer1_bclk_i | input | 1 | Source 3: bit clock of a further audio instance |
| ext_bclk_i | input | 1 | External bit clock, used in slave mode |
| opp_bclk_i | input | 1 | Bit clock of the opposite direction, used by swap |
| src_sel | input | 2 | Divider source select |
| half_div | input | DIV_W | Divider field: ratio/2 - 1 |
| master | input | 1 | 1 generates the clock, 0 passes the external clock through |
| swap | input | 1 | Borrow the opposite direction's clock |
| async_mode | input | 1 | 1 when the path runs asynchronously |
| bclk_en | input | 1 | Bit-clock enable |
| bclk_o | output | 1 | Bit clock |
| bclk_active_o | output | 1 | Bit clock is running |

## Verification
Two events can fall in the same cycle: a disable request and a high phase still in progress. To provoke this, the bench drops the enable one cycle after a rising edge. It then checks two things: the remaining high time adds up to a full half period, and the output stays low afterwards.

A soft reset can also collide with a running high phase. The bench pulses it mid-pulse and judges the result on the next sample, which must be low. The first pulse after release must have full width.

// File: rtl/abg_pkg.sv
package abg_pkg;
   localparam int SEL_W = 2;
   localparam int N_SRC = 1 << SEL_W;

   typedef enum logic [SEL_W-1:0] {
      SRC_BUS   = 2'd0,
      SRC_MDIV  = 2'd1,
      SRC_PEER0 = 2'd2,
      SRC_PEER1 = 2'd3
   } src_e;
endpackage

// File: rtl/abg_edge_sync.sv
module abg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   initial begin
      if (STAGES < 2) $error("abg_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] shr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shr <= '0;
      else        shr <= {shr[STAGES-1:0], async_i};
   end

   assign level_o = shr[STAGES-1];
   assign rise_o  = shr[STAGES-1] & ~shr[STAGES];
endmodule

// File: rtl/abg_divider.sv
module abg_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             tick,
   input  logic             en,
   input  logic [DIV_W-1:0] half_div,
   output logic             bclk_o,
   output logic             running_o
);
   initial begin
      if (DIV_W < 1) $error("abg_divider: DIV_W must be positive");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             phase_q;
   logic             run_q;
   logic             en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
         run_q   <= 1'b0;
         en_q    <= 1'b0;
      end else if (soft_rst) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
         run_q   <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         en_q <= en;
         if (!run_q) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            if (en && !en_q) run_q <= 1'b1;
         end else if (!en && !phase_q) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else if (tick) begin
            if (cnt_q >= half_div) begin
               cnt_q   <= '0;
               phase_q <= ~phase_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign bclk_o    = phase_q;
   assign running_o = run_q;

   // R6: a stopped generator holds its output low
   p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !phase_q);

   // R6: the run flag only drops out of a low phase (or by soft reset)
   p_stop_at_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_q) && !$past(soft_rst)) |-> !$past(phase_q));

   // R4: the phase only moves on a source tick
   p_toggle_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q != $past(phase_q)) && !$past(soft_rst) && $past(run_q)) |-> $past(tick));

   // R5: a start begins from a cleared counter in the low phase
   p_start_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> (cnt_q == '0 && !phase_q));
endmodule

// File: rtl/audio_bclk_gen.sv
module audio_bclk_gen #(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    soft_rst,
   input  logic                    bus_clk_i,
   input  logic                    mdiv_clk_i,
   input  logic                    peer0_bclk_i,
   input  logic                    peer1_bclk_i,
   input  logic                    ext_bclk_i,
   input  logic                    opp_bclk_i,
   input  logic [abg_pkg::SEL_W-1:0] src_sel,
   input  logic [DIV_W-1:0]        half_div,
   input  logic                    master,
   input  logic                    swap,
   input  logic                    async_mode,
   input  logic                    bclk_en,
   output logic                    bclk_o,
   output logic                    bclk_active_o
);
   import abg_pkg::*;

   initial begin
      if (DIV_W < 1 || DIV_W > 16) $error("audio_bclk_gen: DIV_W out of range");
   end

   logic [N_SRC-1:0] src_raw;
   logic [N_SRC-1:0] src_rise;
   logic [N_SRC-1:0] src_lvl;

   assign src_raw[SRC_BUS]   = bus_clk_i;
   assign src_raw[SRC_MDIV]  = mdiv_clk_i;
   assign src_raw[SRC_PEER0] = peer0_bclk_i;
   assign src_raw[SRC_PEER1] = peer1_bclk_i;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      abg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (src_raw[g]),
         .level_o (src_lvl[g]),
         .rise_o  (src_rise[g])
      );
   end

   logic ext_lvl, ext_rise, opp_lvl, opp_rise;

   abg_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ext_bclk_i), .level_o(ext_lvl), .rise_o(ext_rise));
   abg_edge_sync #(.STAGES(SYNC_STAGES)) u_opp_sync (
      .clk(clk), .rst_n(rst_n), .async_i(opp_bclk_i), .level_o(opp_lvl), .rise_o(opp_rise));

   logic sel_tick;
   assign sel_tick = src_rise[src_sel];

   logic borrow, use_pass, pass_lvl;
   assign borrow   = swap & async_mode;
   assign use_pass = borrow | ~master;
   assign pass_lvl = borrow ? opp_lvl : ext_lvl;

   logic div_bclk, div_run;

   abg_divider #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .tick      (sel_tick),
      .en        (bclk_en & ~use_pass),
      .half_div  (half_div),
      .bclk_o    (div_bclk),
      .running_o (div_run)
   );

   logic pass_q, pass_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_q    <= 1'b0;
         pass_en_q <= 1'b0;
      end else if (soft_rst) begin
         pass_q    <= 1'b0;
         pass_en_q <= 1'b0;
      end else begin
         pass_q    <= bclk_en & pass_lvl;
         pass_en_q <= bclk_en;
      end
   end

   assign bclk_o        = use_pass ? pass_q    : div_bclk;
   assign bclk_active_o = use_pass ? pass_en_q : div_run;

   // R10: the clock is never high while reported idle
   p_out_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bclk_o |-> bclk_active_o);

   // R9: a soft reset leaves the output low on the following cycle
   p_soft_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !bclk_o);

   logic unused_edges;
   assign unused_edges = ^src_lvl ^ ext_rise ^ opp_rise;
endmodule

// File: tb/audio_bclk_gen_tb.sv
module audio_bclk_gen_tb;
   localparam int DIV_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0;
   logic bus_clk = 1'b0, mdiv_clk = 1'b0, peer0 = 1'b0, peer1 = 1'b0;
   logic ext_bclk = 1'b0, opp_bclk = 1'b0;
   logic [1:0] src_sel = 2'd0;
   logic [DIV_W-1:0] half_div = '0;
   logic master = 1'b1, swap = 1'b0, async_mode = 1'b0, bclk_en = 1'b0;
   logic bclk, active;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;
   always #40  bus_clk  = ~bus_clk;
   always #60  mdiv_clk = ~mdiv_clk;
   always #80  peer0    = ~peer0;
   always #100 peer1    = ~peer1;
   always #120 ext_bclk = ~ext_bclk;
   always #140 opp_bclk = ~opp_bclk;

   audio_bclk_gen #(.DIV_W(DIV_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .bus_clk_i(bus_clk), .mdiv_clk_i(mdiv_clk),
      .peer0_bclk_i(peer0), .peer1_bclk_i(peer1),
      .ext_bclk_i(ext_bclk), .opp_bclk_i(opp_bclk),
      .src_sel(src_sel), .half_div(half_div),
      .master(master), .swap(swap), .async_mode(async_mode),
      .bclk_en(bclk_en), .bclk_o(bclk), .bclk_active_o(active)
   );

   function automatic int src_period(input int s);
      case (s)
         0: return 4;
         1: return 6;
         2: return 8;
         default: return 10;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_level(input logic v);
      while (bclk !== v) @(negedge clk);
   endtask

   task automatic measure(output int hi, output int per);
      wait_level(1'b0);
      wait_level(1'b1);
      hi = 0;
      while (bclk === 1'b1) begin @(negedge clk); hi++; end
      per = hi;
      while (bclk === 1'b0) begin @(negedge clk); per++; end
   endtask

   task automatic stop_clock();
      bclk_en = 1'b0;
      while (active === 1'b1) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #4000000;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int hi, per;
      repeat (3) @(negedge clk);
      check("R1 bclk reset", int'(bclk), 0);
      check("R1 active reset", int'(active), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2 R3 R4 R5 sweep over sources and field values
      for (int s = 0; s < 4; s++) begin
         for (int k = 0; k < 3; k++) begin
            int f;
            f = (k == 0) ? 0 : (k == 1) ? 1 : 7;
            src_sel  = 2'(s);
            half_div = DIV_W'(f);
            @(negedge clk);
            bclk_en = 1'b1;
            measure(hi, per);
            check("R5 first pulse full", hi, src_period(s) * (f + 1));
            measure(hi, per);
            check("R2 R3 period", per, 2 * src_period(s) * (f + 1));
            check("R4 duty high", hi, src_period(s) * (f + 1));
            check("R10 active while running", int'(active), 1);
            stop_clock();
         end
      end

      // R6: drop enable right after a rising edge
      src_sel = 2'd1; half_div = 8'd1;
      @(negedge clk);
      bclk_en = 1'b1;
      measure(hi, per);
      wait_level(1'b1);
      hi = 0;
      @(negedge clk); hi++;
      bclk_en = 1'b0;
      while (bclk === 1'b1) begin @(negedge clk); hi++; end
      check("R6 high phase completes", hi, 12);
      begin
         int seen;
         seen = 0;
         repeat (60) begin @(negedge clk); if (bclk === 1'b1) seen++; end
         check("R6 stays low", seen, 0);
      end
      check("R10 idle after drain", int'(active), 0);

      // R9: soft reset during a high phase
      src_sel = 2'd0; half_div = 8'd7;
      @(negedge clk);
      bclk_en = 1'b1;
      measure(hi, per);
      wait_level(1'b1);
      repeat (3) @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      check("R9 low under soft reset", int'(bclk), 0);
      @(negedge clk);
      soft_rst = 1'b0;
      measure(hi, per);
      check("R9 first pulse after soft reset", hi, 32);
      measure(hi, per);
      check("R9 ratio kept", per, 64);
      stop_clock();

      // R7: slave mode
      master = 1'b0;
      begin
         int seen;
         seen = 0;
         repeat (40) begin @(negedge clk); if (bclk === 1'b1) seen++; end
         check("R7 gated when disabled", seen, 0);
      end
      bclk_en = 1'b1;
      measure(hi, per);
      measure(hi, per);
      check("R7 slave period", per, 12);
      check("R7 slave high", hi, 6);
      stop_clock();

      // R8: swap
      master = 1'b1; swap = 1'b1; async_mode = 1'b1;
      src_sel = 2'd0; half_div = 8'd0;
      @(negedge clk);
      bclk_en = 1'b1;
      measure(hi, per);
      measure(hi, per);
      check("R8 swap period", per, 14);
      check("R8 swap high", hi, 7);
      stop_clock();
      async_mode = 1'b0;
      @(negedge clk);
      bclk_en = 1'b1;
      measure(hi, per);
      measure(hi, per);
      check("R8 swap ignored when sync", per, 8);
      stop_clock();
      check("R10 idle at end", int'(active), 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule